// File: doc/BRIEF.md
# Prioritized Safety Supervisor State Machine

This block sequences a safety power-management controller through four operating states: standby, reset, active and safe. Every cycle it gathers the pending events, ranks them by priority level and takes only the winning transition. A power-fail input is the top-level event and forces standby. A global reset comes from an excessive watchdog failure count and forces the reset state. Moves into the safe state rank lowest.

The block drives an active-low reset pin and checks its own output. A two-flop synchronizer brings the pin readback into the clock domain. The block compares that readback with the drive value, delayed by the same number of stages, and records any difference in a sticky flag. The state machine acts on that fault only while the pin is driven high in the active state. A difference seen while the pin is held low can never lead to the safe state.

Top module: `safety_sup_fsm`

## Requirements
- R1: While rst_ni is low and directly after it, state_o is standby (encoding 0), nres_o is 0 and mon_err_o is 0. State encoding: 0 standby, 1 reset, 2 active, 3 safe.
- R2: When pwr_fail_i is high at a clock edge, the state is standby after that edge, whatever the other inputs are.
- R3: In standby, wake_i without pwr_fail_i moves to reset. A global reset condition has no effect in standby.
- R4: glob_rst_o is high exactly when wd_rst_en_i is 1 and wd_fail_cnt_i is greater than 7. Without power fail, it moves reset, active or safe to reset at the next edge. In reset it also restarts the reset timer.
- R5: Reset lasts RST_CYCLES clock cycles (default 4) when no event arrives, and then moves to active.
- R6: In active, err_pin_fail_i moves to safe at the next edge, unless a global reset or power fail is present in the same cycle.
- R7: In active, a readback mismatch seen while the pin is driven high moves to safe, unless mon_dis_i is 1.
- R8: Safe is left only by a global reset or a power fail, and never goes directly to active.
- R9: nres_o is 1 in active and safe and 0 in standby and reset.
- R10: A readback mismatch while nres_o is low sets mon_err_o but never causes a move to safe, including after the next entry into active.
- R11: mon_err_o stays set until a mon_err_clr_i strobe arrives with no new mismatch, and is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_fail_i | input | 1 | Priority I power-fail event |
| wake_i | input | 1 | Request to leave standby |
| wd_fail_cnt_i | input | 4 | Watchdog failure count, saturating at 15 |
| wd_rst_en_i | input | 1 | Enables the global reset on watchdog failure |
| err_pin_fail_i | input | 1 | Error-pin fault flag |
| mon_dis_i | input | 1 | Stops the reset-pin monitor from acting on the state machine |
| mon_err_clr_i | input | 1 | Clear strobe for the monitor error flag |
| nres_rb_i | input | 1 | Reset pin readback, asynchronous |
| state_o | output | 2 | Current state |
| nres_o | output | 1 | Reset pin drive, active low |
| mon_err_o | output | 1 | Sticky reset-pin mismatch flag |
| glob_rst_o | output | 1 | Global reset condition |

## Verification
The assertions check the per-cycle rules on every cycle: a power fail always lands in standby, and a global reset lands in reset. Safe never returns straight to active. Standby never jumps to active or safe. The monitor flag holds until it is cleared. The bench scenarios cover the behaviour that needs history. These are the exact length of the reset state, the ranking of a global reset above a safe request in the same cycle, and the count threshold at 7 and 8. They also show that a mismatch seen with the pin held low never leads to safe, and how the monitor-disable bit gates the move.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_STBY = 2'd0,
    ST_RST  = 2'd1,
    ST_ACT  = 2'd2,
    ST_SAFE = 2'd3
  } sup_state_e;
endpackage

// File: rtl/sup_rst_mon.sv
module sup_rst_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_i,
  input  logic rb_i,
  input  logic clr_i,
  output logic hit_hi_o,
  output logic err_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] rb_q, drv_q;
  logic          drv_prev_q, mism;

  // readback and drive are delayed by the same depth, compare skipped right after a drive edge
  assign mism     = (rb_q[LAST] ^ drv_q[LAST]) && (drv_q[LAST] == drv_prev_q);
  assign hit_hi_o = mism && drv_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q       <= '0;
      drv_q      <= '0;
      drv_prev_q <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      rb_q       <= {rb_q[LAST-1:0], rb_i};
      drv_q      <= {drv_q[LAST-1:0], drv_i};
      drv_prev_q <= drv_q[LAST];
      if (mism)       err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sup_evt.sv
module sup_evt
  import sup_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int FAIL_LIMIT = 7
) (
  input  logic             pwr_fail_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wd_en_i,
  input  logic             err_pin_i,
  input  logic             mon_dis_i,
  input  logic             mon_hit_i,
  input  sup_state_e       state_i,
  output logic             prio1_o,
  output logic             glob_o,
  output logic             safe_o
);
  assign prio1_o = pwr_fail_i;
  assign glob_o  = wd_en_i && (cnt_i > CNT_W'(FAIL_LIMIT));
  assign safe_o  = (state_i == ST_ACT) && (err_pin_i || (mon_hit_i && !mon_dis_i));
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prio1_i,
  input  logic       glob_i,
  input  logic       safe_i,
  input  logic       wake_i,
  output sup_state_e state_o
);
  localparam int TW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

  sup_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    if (prio1_i)                           state_d = ST_STBY;
    else if (glob_i && state_q != ST_STBY) state_d = ST_RST;
    else begin
      unique case (state_q)
        ST_STBY: if (wake_i) state_d = ST_RST;
        ST_RST:  if (tmr_q == TW'(RST_CYCLES - 1)) state_d = ST_ACT;
        ST_ACT:  if (safe_i) state_d = ST_SAFE;
        ST_SAFE: state_d = ST_SAFE;
        default: state_d = ST_STBY;
      endcase
    end
    tmr_d = (state_q == ST_RST && state_d == ST_RST && !glob_i) ? tmr_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STBY;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/safety_sup_fsm.sv
module safety_sup_fsm
  import sup_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int FAIL_LIMIT  = 7,
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_fail_i,
  input  logic             wake_i,
  input  logic [CNT_W-1:0] wd_fail_cnt_i,
  input  logic             wd_rst_en_i,
  input  logic             err_pin_fail_i,
  input  logic             mon_dis_i,
  input  logic             mon_err_clr_i,
  input  logic             nres_rb_i,
  output logic [1:0]       state_o,
  output logic             nres_o,
  output logic             mon_err_o,
  output logic             glob_rst_o
);
  sup_state_e state;
  logic       prio1, glob, safe_req, mon_hit;

  assign nres_o     = (state == ST_ACT) || (state == ST_SAFE);
  assign state_o    = state;
  assign glob_rst_o = glob;

  sup_rst_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drv_i    (nres_o),
    .rb_i     (nres_rb_i),
    .clr_i    (mon_err_clr_i),
    .hit_hi_o (mon_hit),
    .err_o    (mon_err_o)
  );

  sup_evt #(.CNT_W(CNT_W), .FAIL_LIMIT(FAIL_LIMIT)) u_evt (
    .pwr_fail_i (pwr_fail_i),
    .cnt_i      (wd_fail_cnt_i),
    .wd_en_i    (wd_rst_en_i),
    .err_pin_i  (err_pin_fail_i),
    .mon_dis_i  (mon_dis_i),
    .mon_hit_i  (mon_hit),
    .state_i    (state),
    .prio1_o    (prio1),
    .glob_o     (glob),
    .safe_o     (safe_req)
  );

  sup_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prio1_i (prio1),
    .glob_i  (glob),
    .safe_i  (safe_req),
    .wake_i  (wake_i),
    .state_o (state)
  );
endmodule

// File: rtl/sup_chk.sv
module sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_fail_i,
  input logic       mon_err_clr_i,
  input logic [1:0] state_o,
  input logic       mon_err_o,
  input logic       glob_rst_o
);
  // R2
  pwr_fail_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> state_o == 2'd0);

  // R4
  glob_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glob_rst_o && !pwr_fail_i && state_o != 2'd0) |=> state_o == 2'd1);

  // R8
  safe_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |=> state_o != 2'd2);

  // R3
  stby_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |=> state_o == 2'd0 || state_o == 2'd1);

  // R11
  mon_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_err_o && !mon_err_clr_i) |=> mon_err_o);
endmodule

bind safety_sup_fsm sup_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_fail_i    (pwr_fail_i),
  .mon_err_clr_i (mon_err_clr_i),
  .state_o       (state_o),
  .mon_err_o     (mon_err_o),
  .glob_rst_o    (glob_rst_o)
);

// File: tb/sim_safety_sup_fsm.sv
`timescale 1ns/1ps
module sim_safety_sup_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 0, wake = 0, wd_en = 0, err_pin = 0, mon_dis = 0, clr = 0;
  logic [3:0] cnt = '0;
  logic       force_en = 0, force_val = 0;
  logic       rb;
  logic [1:0] state;
  logic       nres, mon_err, glob;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign rb = force_en ? force_val : nres;

  safety_sup_fsm u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pwr_fail), .wake_i(wake),
    .wd_fail_cnt_i(cnt), .wd_rst_en_i(wd_en), .err_pin_fail_i(err_pin),
    .mon_dis_i(mon_dis), .mon_err_clr_i(clr), .nres_rb_i(rb),
    .state_o(state), .nres_o(nres), .mon_err_o(mon_err), .glob_rst_o(glob)
  );

  // {pwr, wake, en, errp, cnt[3:0], expected state[1:0]}
  localparam int NV = 31;
  localparam logic [9:0] VEC [NV] = '{
    10'b0100000001, 10'b0000000001, 10'b0000000001, 10'b0000000001, 10'b0000000010,
    10'b0001000011, 10'b0000000011, 10'b0010100001, 10'b0010100001, 10'b0000000001,
    10'b0000000001, 10'b0000000001, 10'b0000000010, 10'b0011111101, 10'b0000000001,
    10'b0000000001, 10'b0000000001, 10'b0000000010, 10'b0000111110, 10'b0010011110,
    10'b1010100000, 10'b0010100000, 10'b1100000000, 10'b0100000001, 10'b0000000001,
    10'b0000000001, 10'b0000000001, 10'b0000000010, 10'b0001000011, 10'b0000000011,
    10'b1000000000
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive_low();
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 state in reset", state, 0);
    chk("R1 nres in reset", nres, 0);
    drive_low();
    rst_n = 1'b1;
    step(1);
    chk("R1 state after reset", state, 0);
    chk("R1 mon_err after reset", mon_err, 0);

    // table: R2 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < NV; v++) begin
      drive_low();
      {pwr_fail, wake, wd_en, err_pin, cnt} = VEC[v][9:2];
      #1;
      chk("R4 glob_rst_o", glob, int'(wd_en && cnt > 7));
      step(1);
      chk($sformatf("R2/R3/R4/R5/R6/R8 vector %0d state", v), state, int'(VEC[v][1:0]));
      chk($sformatf("R9 vector %0d nres", v), nres, int'(VEC[v][1:0] >= 2));
    end
    drive_low();
    {pwr_fail, wake, wd_en, err_pin, cnt} = '0;

    // R10: mismatch with pin low in standby
    force_en = 1; force_val = 1;
    step(5);
    chk("R10 flag set while pin low", mon_err, 1);
    chk("R10 standby kept", state, 0);
    drive_low(); wake = 1;
    step(1);
    drive_low(); wake = 0;
    step(8);
    chk("R10 active reached, no safe", state, 2);
    chk("R11 flag still sticky", mon_err, 1);
    drive_low(); force_en = 0;
    step(4);
    drive_low(); clr = 1;
    step(1);
    drive_low(); clr = 0;
    chk("R11 flag cleared", mon_err, 0);

    // R7: mismatch with pin high, gated by disable
    drive_low(); mon_dis = 1; force_en = 1; force_val = 0;
    step(6);
    chk("R7 disabled keeps active", state, 2);
    chk("R7 flag set", mon_err, 1);
    drive_low(); mon_dis = 0;
    step(2);
    chk("R7 safe after enable", state, 3);
    drive_low(); force_en = 0;
    step(4);
    chk("R8 safe held", state, 3);
    drive_low(); wd_en = 1; cnt = 4'd8;
    step(1);
    chk("R8 global reset leaves safe", state, 1);
    drive_low(); wd_en = 0; cnt = 0; pwr_fail = 1;
    step(1);
    chk("R2 power fail in reset", state, 0);
    drive_low(); pwr_fail = 0;
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule